// File: doc/BRIEF.md
# Selectable Bipolar Line Code Encoder

This block turns a unipolar transmit bit stream into a pair of pulse rails, one positive and one negative, using a bipolar line code. The code is picked at run time by a 2-bit select. The choices are plain alternate mark inversion and three zero-suppression codes: an eight-zero substitution, a four-zero substitution with violation-parity tracking, and a channel-word code that forces one bit of an all-zero 8-bit word to a mark. The zero-suppression codes change the data on the line. For that reason any frame check sum must be computed upstream of this block.

Each bit enters when the bit-clock enable is high. It passes through an 8-entry look-ahead line that stores symbols (space, mark, violation). Because the line is that long, a substitution can rewrite bits that were received earlier but have not yet been sent. A final stage assigns polarity. Each mark takes the polarity opposite to the last pulse. Each violation repeats the polarity of the last pulse. Polarity state carries across substitutions and across changes of mode.

Top module: `lc_bipolar_enc`

## Requirements
- R1: During and after a synchronous reset both rails are low. The polarity state is set so that the first pulse after reset is a mark on the positive rail. The HDB3 parity starts even, and the channel-word counter starts at word bit 0.
- R2: The two rails are never high in the same bit period. A space (zero) symbol produces no pulse on either rail.
- R3: With mode 2'b00 (AMI), every input one becomes a pulse of polarity opposite to the previous pulse. Zero runs of any length go out unchanged as spaces.
- R4: With mode 2'b01 (B8ZS), every eighth consecutive unsubstituted zero causes the eight zeros to be sent as 0,0,0,V,B,0,V,B. V repeats the previous pulse polarity and B alternates. A run of seven zeros is not altered.
- R5: With mode 2'b10 (HDB3), every fourth consecutive unsubstituted zero causes the four zeros to be sent as 0,0,0,V if an odd number of pulses was sent since the last violation, and as B,0,0,V if that number was even. A substitution resets the count.
- R6: With mode 2'b11 (B7ZS), input bits are grouped into 8-bit words counted from reset. When all eight bits of a word are zero, its seventh bit is sent as a normal mark. A zero run that spans two words is not altered.
- R7: A bit sampled on the k-th enabled clock edge appears on the rails right after the (k+8)-th enabled edge.
- R8: The rails change only on clock edges where the bit-clock enable is high. The data input is ignored on other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one enabled edge per line bit |
| din | input | 1 | Unipolar transmit data |
| mode | input | 2 | Line code select: 00 AMI, 01 B8ZS, 10 HDB3, 11 B7ZS |
| pos_o | output | 1 | Positive-rail pulse, registered |
| neg_o | output | 1 | Negative-rail pulse, registered |

## Verification
Every rail value is due eight enabled edges after the input bit that produced it. The bench counts enabled edges, not clock cycles, and compares output bit j after the enabled edge that carries input bit j+8, sampling on the falling clock edge. In the runs with gaps, disabled cycles are inserted with the data input toggled. After each such cycle the bench checks that the rails still show the bit due from the preceding enabled edge. Expected symbols and polarities come from a bench model that scans the whole stimulus for each code.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    MODE_AMI  = 2'd0,
    MODE_B8ZS = 2'd1,
    MODE_HDB3 = 2'd2,
    MODE_B7ZS = 2'd3
  } lc_mode_e;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2
  } lc_sym_e;

endpackage

// File: rtl/lc_subst.sv
module lc_subst
  import lc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WORD_BITS = 8,
  parameter int RUN_W     = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_en,
  input  logic     din,
  input  lc_mode_e mode,
  output lc_sym_e  sym_out
);

  localparam int B8_LEN  = 8;
  localparam int HDB_LEN = 4;
  localparam int WCNT_W  = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [RUN_W-1:0]  RUN_MAX  = {RUN_W{1'b1}};
  localparam logic [WCNT_W-1:0] WORD_END = WCNT_W'(WORD_BITS - 1);

  lc_sym_e           line_q [DEPTH];
  lc_sym_e           line_d [DEPTH];
  logic [RUN_W-1:0]  zrun_q, zrun_d;
  logic              par_odd_q, par_odd_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              wzero_q, wzero_d;
  logic              fire_b8, fire_hdb, fire_b7, word_end;

  always_comb begin
    word_end = (wcnt_q == WORD_END);
    fire_b8  = (mode == MODE_B8ZS) && !din && (zrun_q >= RUN_W'(B8_LEN - 1));
    fire_hdb = (mode == MODE_HDB3) && !din && (zrun_q >= RUN_W'(HDB_LEN - 1));
    fire_b7  = (mode == MODE_B7ZS) && !din && word_end && wzero_q;

    line_d[0] = din ? SYM_MARK : SYM_ZERO;
    for (int k = 1; k < DEPTH; k++) line_d[k] = line_q[k-1];

    // newest bit sits at index 0; older bits at higher indices
    if (fire_b8) begin
      line_d[4] = SYM_VIOL;
      line_d[3] = SYM_MARK;
      line_d[1] = SYM_VIOL;
      line_d[0] = SYM_MARK;
    end
    if (fire_hdb) begin
      line_d[0] = SYM_VIOL;
      if (!par_odd_q) line_d[3] = SYM_MARK;
    end
    if (fire_b7) line_d[1] = SYM_MARK;

    if (fire_b8 || fire_hdb)  par_odd_d = 1'b0;
    else if (din || fire_b7)  par_odd_d = ~par_odd_q;
    else                      par_odd_d = par_odd_q;

    if (din || fire_b8 || fire_hdb) zrun_d = '0;
    else if (fire_b7)               zrun_d = RUN_W'(1);
    else if (zrun_q != RUN_MAX)     zrun_d = zrun_q + 1'b1;
    else                            zrun_d = zrun_q;

    wcnt_d  = word_end ? '0 : wcnt_q + 1'b1;
    wzero_d = word_end ? 1'b1 : (wzero_q && !din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) line_q[k] <= SYM_ZERO;
      zrun_q    <= '0;
      par_odd_q <= 1'b0;
      wcnt_q    <= '0;
      wzero_q   <= 1'b1;
    end else if (bit_en) begin
      for (int k = 0; k < DEPTH; k++) line_q[k] <= line_d[k];
      zrun_q    <= zrun_d;
      par_odd_q <= par_odd_d;
      wcnt_q    <= wcnt_d;
      wzero_q   <= wzero_d;
    end
  end

  assign sym_out = line_q[DEPTH-1];

  // R6: the word counter only moves on enabled edges
  a_r6_word_count_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(wcnt_q));

endmodule

// File: rtl/lc_polar.sv
module lc_polar
  import lc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bit_en,
  input  lc_sym_e sym,
  output logic    pos_o,
  output logic    neg_o
);

  logic last_pos_q;  // 1 when the most recent pulse was positive

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
      last_pos_q <= 1'b0;
    end else if (bit_en) begin
      unique case (sym)
        SYM_MARK: begin
          pos_o      <= ~last_pos_q;
          neg_o      <= last_pos_q;
          last_pos_q <= ~last_pos_q;
        end
        SYM_VIOL: begin
          pos_o <= last_pos_q;
          neg_o <= ~last_pos_q;
        end
        default: begin
          pos_o <= 1'b0;
          neg_o <= 1'b0;
        end
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pos_o && !neg_o));

  a_r2_one_rail: assert property (@(posedge clk) disable iff (rst)
    !(pos_o && neg_o));

  a_r2_space_quiet: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sym == SYM_ZERO) |=> (!pos_o && !neg_o));

  a_r3_mark_pulses: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sym != SYM_ZERO) |=> (pos_o || neg_o));

  a_r8_hold_rails: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(pos_o) && $stable(neg_o)));

endmodule

// File: rtl/lc_bipolar_enc.sv
module lc_bipolar_enc
  import lc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WORD_BITS = 8,
  parameter int RUN_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       din,
  input  logic [1:0] mode,
  output logic       pos_o,
  output logic       neg_o
);

  lc_mode_e mode_e;
  lc_sym_e  line_sym;

  assign mode_e = lc_mode_e'(mode);

  lc_subst #(
    .DEPTH     (DEPTH),
    .WORD_BITS (WORD_BITS),
    .RUN_W     (RUN_W)
  ) subst_i (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .din     (din),
    .mode    (mode_e),
    .sym_out (line_sym)
  );

  lc_polar polar_i (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .sym    (line_sym),
    .pos_o  (pos_o),
    .neg_o  (neg_o)
  );

endmodule

// File: tb/lc_bipolar_enc_tb.sv
module lc_bipolar_enc_tb_top;

  localparam int LAT = 8;
  localparam int MAXN = 160;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       din = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       pos_o, neg_o;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  logic stim [MAXN];
  int   slen;
  int   symm [MAXN];   // 0 space, 1 mark, 2 violation
  logic exp_p [MAXN];
  logic exp_n [MAXN];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  lc_bipolar_enc dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .mode(mode),
    .pos_o(pos_o), .neg_o(neg_o)
  );

  task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: rails {pos,neg} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input int n);
    for (int k = 0; k < n; k++) begin
      stim[slen] = b;
      slen++;
    end
  endtask

  task automatic push_rand(input int n);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(lfsr[1:0] == 2'b00, 1);
    end
  endtask

  function automatic void build_model(input int md);
    int run = 0;
    bit par = 1'b0;
    bit lp = 1'b0;
    for (int i = 0; i < slen; i++) begin
      symm[i] = stim[i] ? 1 : 0;
      if (stim[i]) begin
        run = 0;
        par = ~par;
      end else begin
        run++;
      end
      if (md == 1 && !stim[i] && run == 8) begin
        symm[i-4] = 2; symm[i-3] = 1; symm[i-1] = 2; symm[i] = 1;
        run = 0; par = 1'b0;
      end
      if (md == 2 && !stim[i] && run == 4) begin
        if (!par) symm[i-3] = 1;
        symm[i] = 2;
        run = 0; par = 1'b0;
      end
      if (md == 3 && (i % 8) == 7) begin
        bit allz = 1'b1;
        for (int k = i - 7; k <= i; k++) if (stim[k]) allz = 1'b0;
        if (allz) begin
          symm[i-1] = 1;
          par = ~par;
        end
      end
    end
    for (int i = 0; i < slen; i++) begin
      if (symm[i] == 1) begin
        exp_p[i] = ~lp; exp_n[i] = lp; lp = ~lp;
      end else if (symm[i] == 2) begin
        exp_p[i] = lp; exp_n[i] = ~lp;
      end else begin
        exp_p[i] = 1'b0; exp_n[i] = 1'b0;
      end
    end
  endfunction

  // drive the stimulus; check output bit i-LAT after each enabled edge
  task automatic run_seq(input logic [1:0] md, input string req, input bit gaps);
    build_model(md);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; mode = md;
    @(negedge clk);
    @(negedge clk);
    check(!pos_o && !neg_o, "R1", {pos_o, neg_o}, 2'b00);
    rst = 1'b0;
    for (int i = 0; i < slen; i++) begin
      din = stim[i]; bit_en = 1'b1;
      @(negedge clk);
      if (i >= LAT) begin
        check(pos_o === exp_p[i-LAT] && neg_o === exp_n[i-LAT], req,
              {pos_o, neg_o}, {exp_p[i-LAT], exp_n[i-LAT]});
        check(!(pos_o && neg_o), "R2", {pos_o, neg_o}, {exp_p[i-LAT], exp_n[i-LAT]});
      end else begin
        // R7: nothing reaches the rails before eight enabled edges
        check(!pos_o && !neg_o, "R7", {pos_o, neg_o}, 2'b00);
      end
      if (gaps && (i % 3) == 1) begin
        bit_en = 1'b0; din = ~din;
        @(negedge clk);
        if (i >= LAT)
          check(pos_o === exp_p[i-LAT] && neg_o === exp_n[i-LAT], "R8",
                {pos_o, neg_o}, {exp_p[i-LAT], exp_n[i-LAT]});
      end
    end
    bit_en = 1'b0;
  endtask

  initial begin
    // R3: AMI, alternating marks and long zero runs left as spaces
    slen = 0;
    push(1, 3); push(0, 20); push(1, 1); push(0, 2); push(1, 2);
    push_rand(40); push(0, LAT);
    run_seq(2'd0, "R3", 1'b0);

    // R4: B8ZS, runs of 8, 16 and 7 zeros, leading zeros after reset
    slen = 0;
    push(0, 8); push(1, 1); push(0, 8); push(1, 2); push(0, 16); push(1, 1);
    push(0, 7); push(1, 2); push(0, 9); push(1, 1);
    push_rand(40); push(0, LAT);
    run_seq(2'd1, "R4", 1'b0);

    // R5: HDB3, even parity from reset, odd and even counts between substitutions
    slen = 0;
    push(0, 4); push(1, 1); push(0, 4); push(1, 2); push(0, 4); push(0, 8);
    push(1, 3); push(0, 5); push(1, 1); push(0, 3); push(1, 1);
    push_rand(40); push(0, LAT);
    run_seq(2'd2, "R5", 1'b0);

    // R6: B7ZS, aligned zero words, a word with one mark, a run across words
    slen = 0;
    push(0, 8); push(1, 1); push(0, 7); push(0, 4); push(1, 4);
    push(0, 4); push(0, 4); push(1, 1); push(0, 3); push(0, 16);
    push_rand(40); push(0, LAT);
    run_seq(2'd3, "R6", 1'b0);

    // R8/R7 with enable gaps across every code
    for (int md = 0; md < 4; md++) begin
      slen = 0;
      push(0, 9); push(1, 2); push(0, 12); push_rand(50); push(0, LAT);
      run_seq(2'(md), md == 0 ? "R3" : md == 1 ? "R4" : md == 2 ? "R5" : "R6", 1'b1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule